// File: doc/BRIEF.md
# Power Mode Sequencer for a Decoder Core

The block holds the operating mode of a decoder core in one of four states: RUN, WAIT, SLEEP and PWRDOWN. Mode changes come from decoded host command bytes, each marked by a one-cycle strobe, and from two level pins: a wake request and a power-down request. From the current state it drives the enables for the core clock, the peripheral clock, the analog converters and the PLL. It also reports a two-bit state code.

Commands and pin use follow legality rules. The core can be put to sleep only from WAIT. Power-down is only allowed from SLEEP. A request that breaks these rules leaves the state unchanged and sets a sticky error flag. When power-down ends, a timer built from a microsecond prescaler keeps the block in SLEEP until the PLL has had time to settle. A wake request that arrives during this window is stored and carried out when the window closes.

Top module: `pwr_mode_ctrl`

## Requirements
- R1: After reset (rst_ni low) the state is WAIT, err_o is 0 and the enables take their WAIT values.
- R2: In WAIT, a strobed command 8'h01 or any command from 8'h04 to 8'h09 moves to RUN, and 8'h0F moves to SLEEP. Every other byte leaves the state unchanged and raises no error. The new state appears one clock after the strobe is sampled.
- R3: In RUN, command 8'h00 returns to WAIT. Commands 8'h01, 8'h04 to 8'h09 and 8'h0F set err_o and leave the state at RUN. All other bytes are ignored.
- R4: In SLEEP, pwrdn_i high moves to PWRDOWN and takes priority over wakeup_i. Outside a settle window, wakeup_i high moves to WAIT.
- R5: In PWRDOWN the state holds while pwrdn_i is high, and wakeup_i has no effect. When pwrdn_i is sampled low the state moves to SLEEP and a settle window starts.
- R6: A settle window lasts N = CLK_PER_US*SETTLE_US clocks. SLEEP is not left for WAIT before the Nth clock after the PWRDOWN exit. A wake request sampled at clock j+1 makes WAIT appear at clock max(N, j+1). Re-entering PWRDOWN discards a stored wake request.
- R7: State codes are WAIT=0, RUN=1, SLEEP=2 and PWRDOWN=3. The enables {core, peripheral, analog, pll} are 0111 in WAIT, 1111 in RUN, 0001 in SLEEP and 0000 in PWRDOWN.
- R8: pwrdn_i high while in WAIT or RUN sets err_o. It never moves the state toward PWRDOWN, and a command strobed in the same cycle still acts.
- R9: In SLEEP or PWRDOWN, a strobed mode command (8'h00, 8'h01, 8'h04 to 8'h09, 8'h0F) sets err_o and is ignored. Any other byte is ignored without an error.
- R10: err_o stays set until the next reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_i | input | 8 | Decoded host command byte |
| cmd_valid_i | input | 1 | One-cycle strobe that marks cmd_i as valid |
| wakeup_i | input | 1 | Wake request pin |
| pwrdn_i | input | 1 | Power-down request pin |
| core_clk_en_o | output | 1 | Core clock enable |
| per_clk_en_o | output | 1 | Peripheral clock enable |
| ana_en_o | output | 1 | ADC/DAC enable |
| pll_en_o | output | 1 | PLL enable |
| state_o | output | 2 | Current state code |
| err_o | output | 1 | Sticky flag for an illegal command or pin use |

## Verification
The bench builds the block with CLK_PER_US=2 and SETTLE_US=5, which gives a 10-clock settle window. With a window this short, every wake arrival offset can be tried, from the first clock after the PWRDOWN exit to past expiry. Each offset has its exit clock computed as a maximum. Every one of the 256 command bytes is swept in WAIT, RUN and SLEEP. Pin misuse, priority cases and discarding of a stored wake request on re-entry to PWRDOWN are each driven in their own sequence.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int CMD_W = 8;

  typedef enum logic [1:0] {
    PM_WAIT    = 2'd0,
    PM_RUN     = 2'd1,
    PM_SLEEP   = 2'd2,
    PM_PWRDOWN = 2'd3
  } pm_state_e;

  localparam logic [CMD_W-1:0] CMD_HALT      = 8'h00;
  localparam logic [CMD_W-1:0] CMD_PLAY      = 8'h01;
  localparam logic [CMD_W-1:0] CMD_VOX_FIRST = 8'h04;
  localparam logic [CMD_W-1:0] CMD_VOX_LAST  = 8'h09;
  localparam logic [CMD_W-1:0] CMD_NAP       = 8'h0F;

  function automatic logic is_start_cmd(logic [CMD_W-1:0] c);
    return (c == CMD_PLAY) || ((c >= CMD_VOX_FIRST) && (c <= CMD_VOX_LAST));
  endfunction

  function automatic logic is_mode_cmd(logic [CMD_W-1:0] c);
    return is_start_cmd(c) || (c == CMD_HALT) || (c == CMD_NAP);
  endfunction
endpackage

// File: rtl/pmc_settle_timer.sv
module pmc_settle_timer #(
  parameter int CLK_PER_US = 17,
  parameter int SETTLE_US  = 150
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int PW = (CLK_PER_US > 1) ? $clog2(CLK_PER_US) : 1;
  localparam int UW = $clog2(SETTLE_US + 1);
  localparam logic [PW-1:0] PRE_LAST = PW'(CLK_PER_US - 1);
  localparam logic [UW-1:0] US_LOAD  = UW'(SETTLE_US);

  logic [PW-1:0] pre_q;
  logic [UW-1:0] us_q;
  logic          busy_q;
  logic          tick;

  assign tick   = busy_q && (pre_q == PRE_LAST);
  assign busy_o = busy_q;
  assign done_o = tick && (us_q == UW'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      pre_q  <= '0;
      us_q   <= '0;
    end else if (start_i) begin
      busy_q <= 1'b1;
      pre_q  <= '0;
      us_q   <= US_LOAD;
    end else if (busy_q) begin
      if (tick) begin
        pre_q <= '0;
        us_q  <= us_q - UW'(1);
        if (us_q == UW'(1)) busy_q <= 1'b0;
      end else begin
        pre_q <= pre_q + PW'(1);
      end
    end
  end
endmodule

// File: rtl/pmc_fsm.sv
module pmc_fsm
  import pmc_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cmd_valid_i,
  input  logic             wakeup_i,
  input  logic             pwrdn_i,
  input  logic             settle_busy_i,
  input  logic             settle_done_i,
  output pm_state_e        state_o,
  output logic             settle_start_o,
  output logic             err_o
);
  pm_state_e state_q, state_n;
  logic      pend_q, pend_n;
  logic      err_q, err_set;
  logic      start_v, mode_v, settling;

  assign start_v  = cmd_valid_i && is_start_cmd(cmd_i);
  assign mode_v   = cmd_valid_i && is_mode_cmd(cmd_i);
  assign settling = settle_busy_i && !settle_done_i;

  always_comb begin
    state_n        = state_q;
    pend_n         = pend_q;
    err_set        = 1'b0;
    settle_start_o = 1'b0;
    unique case (state_q)
      PM_WAIT: begin
        if (start_v) state_n = PM_RUN;
        else if (cmd_valid_i && cmd_i == CMD_NAP) state_n = PM_SLEEP;
        if (pwrdn_i) err_set = 1'b1;
      end
      PM_RUN: begin
        if (cmd_valid_i && cmd_i == CMD_HALT) state_n = PM_WAIT;
        else if (start_v || (cmd_valid_i && cmd_i == CMD_NAP)) err_set = 1'b1;
        if (pwrdn_i) err_set = 1'b1;
      end
      PM_SLEEP: begin
        if (mode_v) err_set = 1'b1;
        if (pwrdn_i) begin
          state_n = PM_PWRDOWN;
          pend_n  = 1'b0;
        end else if (settling) begin
          if (wakeup_i) pend_n = 1'b1;
        end else if (wakeup_i || pend_q) begin
          state_n = PM_WAIT;
          pend_n  = 1'b0;
        end
      end
      PM_PWRDOWN: begin
        if (mode_v) err_set = 1'b1;
        if (!pwrdn_i) begin
          state_n        = PM_SLEEP;
          settle_start_o = 1'b1;
        end
      end
      default: state_n = PM_WAIT;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= PM_WAIT;
      pend_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_n;
      pend_q  <= pend_n;
      err_q   <= err_q | err_set;
    end
  end

  assign state_o = state_q;
  assign err_o   = err_q;
endmodule

// File: rtl/pmc_gate_map.sv
module pmc_gate_map
  import pmc_pkg::*;
(
  input  pm_state_e state_i,
  output logic      core_clk_en_o,
  output logic      per_clk_en_o,
  output logic      ana_en_o,
  output logic      pll_en_o
);
  logic [3:0] en;

  always_comb begin
    unique case (state_i)
      PM_RUN:     en = 4'b1111;
      PM_WAIT:    en = 4'b0111;
      PM_SLEEP:   en = 4'b0001;
      PM_PWRDOWN: en = 4'b0000;
      default:    en = 4'b0000;
    endcase
  end

  assign {core_clk_en_o, per_clk_en_o, ana_en_o, pll_en_o} = en;
endmodule

// File: rtl/pwr_mode_ctrl.sv
module pwr_mode_ctrl
  import pmc_pkg::*;
#(
  parameter int CLK_PER_US = 17,
  parameter int SETTLE_US  = 150
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CMD_W-1:0] cmd_i,
  input  logic             cmd_valid_i,
  input  logic             wakeup_i,
  input  logic             pwrdn_i,
  output logic             core_clk_en_o,
  output logic             per_clk_en_o,
  output logic             ana_en_o,
  output logic             pll_en_o,
  output logic [1:0]       state_o,
  output logic             err_o
);
  pm_state_e state;
  logic      settle_start, settle_busy, settle_done;

  pmc_settle_timer #(
    .CLK_PER_US(CLK_PER_US),
    .SETTLE_US (SETTLE_US)
  ) u_timer (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .start_i(settle_start),
    .busy_o (settle_busy),
    .done_o (settle_done)
  );

  pmc_fsm u_fsm (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .cmd_i         (cmd_i),
    .cmd_valid_i   (cmd_valid_i),
    .wakeup_i      (wakeup_i),
    .pwrdn_i       (pwrdn_i),
    .settle_busy_i (settle_busy),
    .settle_done_i (settle_done),
    .state_o       (state),
    .settle_start_o(settle_start),
    .err_o         (err_o)
  );

  pmc_gate_map u_map (
    .state_i      (state),
    .core_clk_en_o(core_clk_en_o),
    .per_clk_en_o (per_clk_en_o),
    .ana_en_o     (ana_en_o),
    .pll_en_o     (pll_en_o)
  );

  assign state_o = state;
endmodule

// File: rtl/pmc_checker.sv
module pmc_checker #(
  parameter int CLK_PER_US = 17,
  parameter int SETTLE_US  = 150
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       pwrdn_i,
  input logic       core_clk_en_o,
  input logic       per_clk_en_o,
  input logic       ana_en_o,
  input logic       pll_en_o,
  input logic [1:0] state_o,
  input logic       err_o
);
  localparam int WIN = CLK_PER_US * SETTLE_US;
  localparam int CW  = $clog2(WIN + 1);
  localparam logic [1:0] S_WAIT = 2'd0, S_RUN = 2'd1, S_SLEEP = 2'd2, S_PD = 2'd3;

  logic [CW-1:0] win_q;
  logic          armed_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q   <= '0;
      armed_q <= 1'b0;
    end else if (state_o == S_PD) begin
      win_q   <= '0;
      armed_q <= 1'b1;
    end else if (state_o != S_SLEEP) begin
      armed_q <= 1'b0;
    end else if (armed_q && win_q != CW'(WIN)) begin
      win_q <= win_q + CW'(1);
    end
  end

  assert_pd_all_off_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_PD) |-> !(core_clk_en_o || per_clk_en_o || ana_en_o || pll_en_o));
  assert_core_only_run_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    core_clk_en_o |-> (state_o == S_RUN));
  assert_err_sticky_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |=> err_o);
  assert_pwrdn_misuse_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_o == S_WAIT || state_o == S_RUN) && pwrdn_i) |=> err_o);
  assert_wait_no_pd_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_WAIT) |=> (state_o != S_PD));
  assert_run_exit_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_RUN) |=> (state_o == S_RUN || state_o == S_WAIT));
  assert_pd_entry_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_SLEEP && pwrdn_i) |=> (state_o == S_PD));
  assert_pd_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_PD && pwrdn_i) |=> (state_o == S_PD));
  assert_settle_hold_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_o == S_SLEEP && armed_q && win_q < CW'(WIN - 1)) |=> (state_o != S_WAIT));
endmodule

bind pwr_mode_ctrl pmc_checker #(
  .CLK_PER_US(CLK_PER_US),
  .SETTLE_US (SETTLE_US)
) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .pwrdn_i      (pwrdn_i),
  .core_clk_en_o(core_clk_en_o),
  .per_clk_en_o (per_clk_en_o),
  .ana_en_o     (ana_en_o),
  .pll_en_o     (pll_en_o),
  .state_o      (state_o),
  .err_o        (err_o)
);

// File: tb/sim_pwr_mode_ctrl.sv
`timescale 1ns/1ps
module sim_pwr_mode_ctrl;
  localparam int CPU = 2;
  localparam int SUS = 5;
  localparam int N   = CPU * SUS;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] cmd_i = 8'h00;
  logic       cmd_valid_i = 1'b0;
  logic       wakeup_i = 1'b0;
  logic       pwrdn_i = 1'b0;
  logic       core_en, per_en, ana_en, pll_en, err_o;
  logic [1:0] state_o;
  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  pwr_mode_ctrl #(.CLK_PER_US(CPU), .SETTLE_US(SUS)) u0 (
    .clk_i(clk), .rst_ni(rst_ni), .cmd_i(cmd_i), .cmd_valid_i(cmd_valid_i),
    .wakeup_i(wakeup_i), .pwrdn_i(pwrdn_i), .core_clk_en_o(core_en),
    .per_clk_en_o(per_en), .ana_en_o(ana_en), .pll_en_o(pll_en),
    .state_o(state_o), .err_o(err_o)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic int exp_en(int s);
    case (s)
      0: return 7;
      1: return 15;
      2: return 1;
      default: return 0;
    endcase
  endfunction

  function automatic bit is_start(int c);
    return c == 1 || (c >= 4 && c <= 9);
  endfunction

  function automatic bit is_mode(int c);
    return is_start(c) || c == 0 || c == 15;
  endfunction

  function automatic int en_now();
    return {core_en, per_en, ana_en, pll_en};
  endfunction

  task automatic do_reset();
    @(negedge clk);
    rst_ni = 1'b0; wakeup_i = 1'b0; pwrdn_i = 1'b0; cmd_valid_i = 1'b0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
  endtask

  task automatic send(input int c);
    cmd_i = 8'(c); cmd_valid_i = 1'b1;
    @(negedge clk);
    cmd_valid_i = 1'b0;
  endtask

  task automatic into_pd();
    do_reset();
    send(15);
    pwrdn_i = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    do_reset();
    chk("R1 state", state_o, 0);
    chk("R1 err", err_o, 0);
    chk("R1/R7 enables", en_now(), 7);

    // R2: full sweep in WAIT
    for (int c = 0; c < 256; c++) begin
      int es;
      do_reset();
      send(c);
      es = is_start(c) ? 1 : (c == 15 ? 2 : 0);
      chk($sformatf("R2 cmd %0h state", c), state_o, es);
      chk("R2 err", err_o, 0);
      chk("R7 enables", en_now(), exp_en(es));
    end

    // R3: full sweep in RUN
    for (int c = 0; c < 256; c++) begin
      do_reset();
      send(1);
      send(c);
      chk($sformatf("R3 cmd %0h state", c), state_o, c == 0 ? 0 : 1);
      chk("R3 err", err_o, (is_start(c) || c == 15) ? 1 : 0);
    end

    // R9: full sweep in SLEEP
    for (int c = 0; c < 256; c++) begin
      do_reset();
      send(15);
      send(c);
      chk($sformatf("R9 sleep cmd %0h state", c), state_o, 2);
      chk("R9 sleep err", err_o, is_mode(c) ? 1 : 0);
    end

    // R4: wake from plain SLEEP
    do_reset();
    send(15);
    wakeup_i = 1'b1;
    @(negedge clk);
    wakeup_i = 1'b0;
    chk("R4 wake to WAIT", state_o, 0);

    // R4/R5: pwrdn priority, hold, wake ignored, mode cmd in PWRDOWN
    do_reset();
    send(15);
    pwrdn_i = 1'b1; wakeup_i = 1'b1;
    @(negedge clk);
    chk("R4 pwrdn priority", state_o, 3);
    chk("R7 pd enables", en_now(), 0);
    for (int k = 0; k < 4; k++) begin
      wakeup_i = k[0];
      @(negedge clk);
      chk("R5 hold", state_o, 3);
    end
    wakeup_i = 1'b0;
    chk("R5 err clean", err_o, 0);
    send(1);
    chk("R9 pd cmd state", state_o, 3);
    chk("R9 pd cmd err", err_o, 1);
    send(8'h22);
    chk("R9 pd non-mode", state_o, 3);

    // R6: every wake offset across the settle window
    for (int j = 0; j <= N + 2; j++) begin
      int a;
      a = (j + 1 > N) ? j + 1 : N;
      into_pd();
      pwrdn_i = 1'b0;
      for (int m = 0; m <= a + 1; m++) begin
        @(negedge clk);
        chk($sformatf("R6 j=%0d m=%0d", j, m), state_o, m < a ? 2 : 0);
        wakeup_i = (m == j);
      end
      wakeup_i = 1'b0;
    end

    // R6: no wake keeps SLEEP; re-entry drops stored wake
    into_pd();
    pwrdn_i = 1'b0;
    @(negedge clk);
    wakeup_i = 1'b1;
    @(negedge clk);
    wakeup_i = 1'b0; pwrdn_i = 1'b1;
    @(negedge clk);
    chk("R5 re-enter PD", state_o, 3);
    pwrdn_i = 1'b0;
    for (int m = 0; m < N + 4; m++) begin
      @(negedge clk);
      chk("R6 stored wake dropped", state_o, 2);
    end
    wakeup_i = 1'b1;
    @(negedge clk);
    wakeup_i = 1'b0;
    chk("R6 wake after window", state_o, 0);

    // R8/R10: pin misuse in WAIT and RUN
    do_reset();
    pwrdn_i = 1'b1;
    @(negedge clk);
    pwrdn_i = 1'b0;
    chk("R8 wait pwrdn state", state_o, 0);
    chk("R8 wait pwrdn err", err_o, 1);
    send(1);
    chk("R10 err kept", err_o, 1);
    chk("R8 cmd still acts", state_o, 1);
    pwrdn_i = 1'b1;
    @(negedge clk);
    pwrdn_i = 1'b0;
    chk("R8 run pwrdn state", state_o, 1);
    do_reset();
    @(negedge clk);
    chk("R10 reset clears", err_o, 0);
    send(1);
    pwrdn_i = 1'b1; cmd_i = 8'h00; cmd_valid_i = 1'b1;
    @(negedge clk);
    pwrdn_i = 1'b0; cmd_valid_i = 1'b0;
    chk("R8 same-cycle halt", state_o, 0);
    chk("R8 same-cycle err", err_o, 1);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule